// File: doc/BRIEF.md
# Programmable sum-of-products logic array

This block is a small reconfigurable logic device. Ten dedicated inputs and the fed-back state of six outputs form a 16-wide array input. Each of eight outputs sums eight product terms, and each product term is an AND of chosen true or complemented array inputs. Every output passes through a macrocell. The macrocell can be set to registered or combinational and to either polarity, and it has an output enable built from one extra product term.

All links and macrocell settings live in a volatile configuration image of 2320 bits. The image is shifted in serially, and it can be shifted back out for verification unless a sticky lock bit has been set. The lock can only be removed by a full erase, which also wipes every link. Until a complete image has been loaded, every output is disabled.

Top module: `sop_logic_core`

## Requirements
- R1: The image is shifted in most significant bit first, one bit per clock while `ld_en` is high. Image bit 2319 enters first. `cfg_ok` rises on the clock after `ld_en` falls, and only if exactly 2320 bits were shifted. It is low while loading and after a short or long load. While `cfg_ok` is low, `pin_oe` is all zero.
- R2: Image layout: output o owns bits o*290 to o*290+289. Bit +0 selects registered mode and bit +1 selects active-low. Product term t (0..7 are sum terms, 8 is the enable term) starts at +2+32*t. Within a term, the true link of array input i is at +2*i and the complement link is at +2*i+1. Array inputs 0..9 are `dat_in`, and array inputs 10..15 are the feedback of outputs 0..5. Each output's sum is the OR of its eight sum terms.
- R3: In registered mode the output shows a flop that captures the sum on every clock edge while configured.
- R4: Active-low inverts the registered or combinational value before the pin.
- R5: A sum term with no links evaluates to 0. A term that links the same input both true and complemented also evaluates to 0.
- R6: The pin is enabled when the enable term is true. An enable term with no links is always true. A disabled pin drives `pin_oe`=0 and `pin_q`=0, so the pad is high impedance.
- R7: In registered mode the feedback of an output is its flop value, before polarity.
- R8: In combinational mode the feedback is the value captured at the previous clock edge. That value is the pin value (after polarity) if the pin was enabled, and the raw sum otherwise.
- R9: Each clock with `rb_en` high (and `ld_en` low) moves the readback pointer down by one. `rb_bit` presents the image bit at the pointer. The pointer starts at bit 2319 after reset, load or erase, and wraps from 0 back to 2319.
- R10: After a `lock_req` pulse, `rb_bit` stays 0 until an erase, even across a reload.
- R11: An `erase_req` pulse clears every link, the lock and `cfg_ok`.
- R12: Reset clears the image, the lock and `cfg_ok`. The output flops and feedback captures are cleared while `cfg_ok` is low, so the first registered pin value after a load is 0 xor active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dat_in | input | 10 | Dedicated logic inputs |
| pin_q | output | 8 | Output values, 0 when disabled |
| pin_oe | output | 8 | Per-output drive enables |
| ld_en | input | 1 | Serial load enable |
| ld_bit | input | 1 | Serial load data |
| rb_en | input | 1 | Readback advance |
| rb_bit | output | 1 | Readback data |
| lock_req | input | 1 | Sets the readback lock |
| erase_req | input | 1 | Full erase |
| cfg_ok | output | 1 | Complete image present |

## Verification
The bench sweeps all 1024 input words, in two orders, over a directed image and two pseudo-random images, and checks them against an arithmetic sum-of-products model. The directed image targets empty and self-contradicting terms, which a wrong design would let pull an output high. It also targets an enable term tied to one input, which a wrong design would leave driving. Registered and combinational feedback is covered too; an off-by-one in the capture would show as the seventh output lagging or leading by a cycle. Readback is compared bit for bit after a load and must stay at zero after a lock and across a reload, and a short load must never raise `cfg_ok`.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;

    localparam int SOP_N_IN  = 10;
    localparam int SOP_N_OUT = 8;
    localparam int SOP_N_FB  = 6;
    localparam int SOP_N_PT  = 8;

    typedef enum logic [1:0] {
        CFG_EMPTY,
        CFG_LOADING,
        CFG_READY
    } cfg_state_e;

    typedef struct packed {
        logic reg_mode;
        logic act_low;
    } mc_mode_t;

    typedef struct packed {
        logic val;
        logic en;
        logic fb;
    } mc_out_t;

    // bits of one output's field: two mode bits plus sum terms and the enable term
    function automatic int out_width(int n_arr, int n_pt);
        return 2 + (n_pt + 1) * 2 * n_arr;
    endfunction

    function automatic int mode_base(int o, int n_arr, int n_pt);
        return o * out_width(n_arr, n_pt);
    endfunction

    function automatic int term_base(int o, int t, int n_arr, int n_pt);
        return mode_base(o, n_arr, n_pt) + 2 + t * 2 * n_arr;
    endfunction

endpackage

// File: rtl/sop_cfg_store.sv
`timescale 1ns/1ps
module sop_cfg_store
    import sop_pkg::*;
#(
    parameter int IMG_W = 2320
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic             ld_bit,
    input  logic             rb_en,
    input  logic             lock_req,
    input  logic             erase_req,
    output logic [IMG_W-1:0] img,
    output logic             cfg_ok,
    output logic             rb_bit
);

    localparam int CW = $clog2(IMG_W + 2);
    localparam logic [CW-1:0] PTR_TOP = CW'(IMG_W - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(IMG_W);
    localparam logic [CW-1:0] CNT_OVER = CW'(IMG_W + 1);

    logic [IMG_W-1:0] chain;
    logic             locked;
    cfg_state_e       st;
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    ptr;

    always_ff @(posedge clk) begin
        if (rst || erase_req) begin
            chain  <= '0;
            locked <= 1'b0;
            st     <= CFG_EMPTY;
            cnt    <= '0;
            ptr    <= PTR_TOP;
        end else begin
            if (lock_req) begin
                locked <= 1'b1;
            end
            if (ld_en) begin
                chain <= {chain[IMG_W-2:0], ld_bit};
                st    <= CFG_LOADING;
                ptr   <= PTR_TOP;
                if (cnt != CNT_OVER) begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                if (st == CFG_LOADING) begin
                    st  <= (cnt == CNT_FULL) ? CFG_READY : CFG_EMPTY;
                    cnt <= '0;
                end
                if (rb_en) begin
                    ptr <= (ptr == '0) ? PTR_TOP : ptr - 1'b1;
                end
            end
        end
    end

    assign img    = chain;
    assign cfg_ok = (st == CFG_READY);
    assign rb_bit = locked ? 1'b0 : chain[ptr];

    p_no_ready_while_loading_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(ld_en) && !$past(rst)) |-> (st != CFG_READY))
        else $error("ready asserted during load");

    p_lock_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(locked) && !$past(erase_req)) |-> locked)
        else $error("lock dropped without erase");

    p_erase_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(erase_req)) |-> (!locked && st == CFG_EMPTY && chain == '0))
        else $error("erase left state behind");

endmodule

// File: rtl/sop_plane.sv
`timescale 1ns/1ps
module sop_plane
    import sop_pkg::*;
#(
    parameter int N_IN  = SOP_N_IN,
    parameter int N_OUT = SOP_N_OUT,
    parameter int N_FB  = SOP_N_FB,
    parameter int N_PT  = SOP_N_PT,
    localparam int N_ARR = N_IN + N_FB,
    localparam int TW    = 2 * N_ARR,
    localparam int IMG_W = N_OUT * out_width(N_ARR, N_PT)
) (
    input  logic [IMG_W-1:0]           img,
    input  logic [N_ARR-1:0]           arr_in,
    output logic [N_OUT-1:0]           sop,
    output logic [N_OUT-1:0]           oe_term,
    output mc_mode_t [N_OUT-1:0]       mode
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        localparam int MB = mode_base(o, N_ARR, N_PT);
        logic [N_PT:0] pt;

        assign mode[o] = '{reg_mode: img[MB], act_low: img[MB+1]};

        for (genvar t = 0; t <= N_PT; t++) begin : g_pt
            localparam int TB = term_base(o, t, N_ARR, N_PT);
            logic [N_ARR-1:0] miss;

            for (genvar i = 0; i < N_ARR; i++) begin : g_lit
                assign miss[i] = (img[TB+2*i] & ~arr_in[i]) | (img[TB+2*i+1] & arr_in[i]);
            end

            if (t < N_PT) begin : g_sum
                // an unlinked sum term must not contribute
                assign pt[t] = ~|miss & |img[TB +: TW];
            end else begin : g_en
                // an unlinked enable term leaves the pin driving
                assign pt[t] = ~|miss;
            end
        end

        assign sop[o]     = |pt[N_PT-1:0];
        assign oe_term[o] = pt[N_PT];
    end

endmodule

// File: rtl/sop_macrocell.sv
`timescale 1ns/1ps
module sop_macrocell
    import sop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cfg_ok,
    input  logic     sop,
    input  logic     oe_term,
    input  mc_mode_t mode,
    output mc_out_t  out
);

    logic q;
    logic hold;
    logic raw;
    logic val;
    logic en;

    assign raw = mode.reg_mode ? q : sop;
    assign val = raw ^ mode.act_low;
    assign en  = cfg_ok & oe_term;

    always_ff @(posedge clk) begin
        if (rst || !cfg_ok) begin
            q    <= 1'b0;
            hold <= 1'b0;
        end else begin
            q    <= sop;
            hold <= en ? val : sop;
        end
    end

    assign out.val = en & val;
    assign out.en  = en;
    assign out.fb  = mode.reg_mode ? q : hold;

    p_flop_captures_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_ok) && cfg_ok) |-> (q == $past(sop)))
        else $error("output flop missed the sum");

endmodule

// File: rtl/sop_logic_core.sv
`timescale 1ns/1ps
module sop_logic_core
    import sop_pkg::*;
#(
    parameter int N_IN  = SOP_N_IN,
    parameter int N_OUT = SOP_N_OUT,
    parameter int N_FB  = SOP_N_FB,
    parameter int N_PT  = SOP_N_PT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IN-1:0]  dat_in,
    output logic [N_OUT-1:0] pin_q,
    output logic [N_OUT-1:0] pin_oe,
    input  logic             ld_en,
    input  logic             ld_bit,
    input  logic             rb_en,
    output logic             rb_bit,
    input  logic             lock_req,
    input  logic             erase_req,
    output logic             cfg_ok
);

    localparam int N_ARR = N_IN + N_FB;
    localparam int IMG_W = N_OUT * out_width(N_ARR, N_PT);

    logic [IMG_W-1:0]     img;
    logic [N_FB-1:0]      fb;
    logic [N_ARR-1:0]     arr_in;
    logic [N_OUT-1:0]     sop;
    logic [N_OUT-1:0]     oe_term;
    mc_mode_t [N_OUT-1:0] mode;
    mc_out_t [N_OUT-1:0]  mc_o;

    assign arr_in = {fb, dat_in};

    sop_cfg_store #(.IMG_W(IMG_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_bit    (ld_bit),
        .rb_en     (rb_en),
        .lock_req  (lock_req),
        .erase_req (erase_req),
        .img       (img),
        .cfg_ok    (cfg_ok),
        .rb_bit    (rb_bit)
    );

    sop_plane #(
        .N_IN  (N_IN),
        .N_OUT (N_OUT),
        .N_FB  (N_FB),
        .N_PT  (N_PT)
    ) u_plane (
        .img     (img),
        .arr_in  (arr_in),
        .sop     (sop),
        .oe_term (oe_term),
        .mode    (mode)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_mc
        sop_macrocell u_mc (
            .clk     (clk),
            .rst     (rst),
            .cfg_ok  (cfg_ok),
            .sop     (sop[o]),
            .oe_term (oe_term[o]),
            .mode    (mode[o]),
            .out     (mc_o[o])
        );
        assign pin_q[o]  = mc_o[o].val;
        assign pin_oe[o] = mc_o[o].en;
        if (o < N_FB) begin : g_fb
            assign fb[o] = mc_o[o].fb;
        end else begin : g_nofb
            logic unused_fb;
            assign unused_fb = mc_o[o].fb;
        end
    end

    p_quiet_until_ready_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok |-> (pin_oe == '0 && pin_q == '0))
        else $error("pin driven without a complete image");

endmodule

// File: tb/sim_sop_logic_core.sv
`timescale 1ns/1ps
module sim_sop_logic_core;
    import sop_pkg::*;

    localparam int NI = SOP_N_IN;
    localparam int NO = SOP_N_OUT;
    localparam int NF = SOP_N_FB;
    localparam int NP = SOP_N_PT;
    localparam int NA = NI + NF;
    localparam int TW = 2 * NA;
    localparam int OW = 2 + (NP + 1) * TW;
    localparam int IW = NO * OW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] dat_in = '0;
    logic          ld_en = 1'b0, ld_bit = 1'b0, rb_en = 1'b0;
    logic          lock_req = 1'b0, erase_req = 1'b0;
    logic [NO-1:0] pin_q, pin_oe;
    logic          rb_bit, cfg_ok;

    always #2.5 clk = ~clk;

    sop_logic_core u0 (
        .clk(clk), .rst(rst), .dat_in(dat_in), .pin_q(pin_q), .pin_oe(pin_oe),
        .ld_en(ld_en), .ld_bit(ld_bit), .rb_en(rb_en), .rb_bit(rb_bit),
        .lock_req(lock_req), .erase_req(erase_req), .cfg_ok(cfg_ok)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [IW-1:0] cimg;
    bit   [NO-1:0] mq, mh, e_q, e_oe, e_sop, e_val;
    bit            mvalid = 1'b0;
    bit   [31:0]   rs;
    string         tg [NO];

    function automatic int lidx(int o, int t, int i, int c);
        return o * OW + 2 + t * TW + 2 * i + c;
    endfunction

    task automatic set_lnk(int o, int t, int i, int c);
        cimg[lidx(o, t, i, c)] = 1'b1;
    endtask

    task automatic set_md(int o, bit r, bit l);
        cimg[o*OW]   = r;
        cimg[o*OW+1] = l;
    endtask

    task automatic chk(bit ok, string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // reference model of the array, from the requirements
    task automatic model_eval();
        bit [NA-1:0] arr;
        arr[NI-1:0] = dat_in;
        for (int o = 0; o < NF; o++) arr[NI+o] = cimg[o*OW] ? mq[o] : mh[o];
        for (int o = 0; o < NO; o++) begin
            bit s, oe, raw;
            s = 1'b0;
            oe = 1'b0;
            for (int t = 0; t <= NP; t++) begin
                bit any, ok;
                any = 1'b0;
                ok  = 1'b1;
                for (int i = 0; i < NA; i++) begin
                    if (cimg[lidx(o, t, i, 0)]) begin any = 1'b1; if (!arr[i]) ok = 1'b0; end
                    if (cimg[lidx(o, t, i, 1)]) begin any = 1'b1; if (arr[i])  ok = 1'b0; end
                end
                if (t < NP) s = s | (ok & any);
                else        oe = ok;
            end
            raw      = cimg[o*OW] ? mq[o] : s;
            e_sop[o] = s;
            e_val[o] = raw ^ cimg[o*OW+1];
            e_oe[o]  = mvalid & oe;
            e_q[o]   = e_oe[o] & e_val[o];
        end
    endtask

    task automatic model_adv();
        @(posedge clk);
        for (int o = 0; o < NO; o++) begin
            if (!mvalid) begin
                mq[o] = 1'b0;
                mh[o] = 1'b0;
            end else begin
                mq[o] = e_sop[o];
                mh[o] = e_oe[o] ? e_val[o] : e_sop[o];
            end
        end
    endtask

    task automatic step(logic [NI-1:0] x, string why);
        @(negedge clk);
        dat_in = x;
        #1;
        model_eval();
        for (int o = 0; o < NO; o++) begin
            chk(pin_q[o] === e_q[o] && pin_oe[o] === e_oe[o], (why != "") ? why : tg[o],
                $sformatf("out%0d {oe,q} in=%0h", o, x), {30'd0, pin_oe[o], pin_q[o]},
                {30'd0, e_oe[o], e_q[o]});
        end
        model_adv();
    endtask

    task automatic idle();
        @(negedge clk);
        #1;
        model_eval();
        model_adv();
    endtask

    task automatic load_img(int nbits);
        mvalid = 1'b0;
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            ld_en  = 1'b1;
            ld_bit = (k < IW) ? cimg[IW-1-k] : 1'b0;
            if (k == IW / 2) begin
                #1;
                chk(cfg_ok === 1'b0 && pin_oe === '0, "R1", "quiet during load",
                    {23'd0, cfg_ok, pin_oe}, 32'd0);
            end
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(posedge clk);
        mq = '0;
        mh = '0;
        mvalid = (nbits == IW);
        #1;
        chk(cfg_ok === mvalid, "R1", $sformatf("cfg_ok after %0d bits", nbits),
            {31'd0, cfg_ok}, {31'd0, mvalid});
    endtask

    task automatic rb_sweep(bit zeros, string req);
        int bad;
        bad = 0;
        for (int k = 0; k < IW; k++) begin
            @(negedge clk);
            rb_en = 1'b1;
            #1;
            if (rb_bit !== (zeros ? 1'b0 : cimg[IW-1-k])) bad++;
            model_eval();
            model_adv();
        end
        @(negedge clk);
        rb_en = 1'b0;
        #1;
        model_eval();
        model_adv();
        chk(bad == 0, req, zeros ? "readback not blank" : "readback image", bad, 0);
    endtask

    task automatic sweep(string why);
        for (int k = 0; k < 1024; k++) step(NI'(k), why);
        for (int k = 0; k < 1024; k++) step(NI'((k * 37 + 11) % 1024), why);
    endtask

    task automatic build_directed();
        cimg = '0;
        set_md(0, 0, 0); set_lnk(0, 0, 0, 0); set_lnk(0, 0, 1, 0); set_lnk(0, 1, 2, 1);
        set_md(1, 0, 1); set_lnk(1, 0, 3, 0); set_lnk(1, 0, 4, 1);
                         set_lnk(1, 1, 3, 1); set_lnk(1, 1, 4, 0);
        set_md(2, 0, 0);
        set_md(3, 0, 1); set_lnk(3, 0, 5, 0); set_lnk(3, 0, 5, 1);
        set_md(4, 0, 0); set_lnk(4, 0, 9, 0); set_lnk(4, NP, 8, 0);
        set_md(5, 1, 0); set_lnk(5, 0, 6, 0); set_lnk(5, 0, 7, 0);
        set_md(6, 1, 1); set_lnk(6, 0, 0, 0); set_lnk(6, 1, 1, 0);
        set_md(7, 0, 0); set_lnk(7, 0, NI + 5, 0); set_lnk(7, 0, 2, 0);
                         set_lnk(7, 1, NI + 0, 0); set_lnk(7, 1, 2, 1);
    endtask

    function automatic bit [31:0] xs(bit [31:0] v);
        v = v ^ (v << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic build_random(bit [31:0] seed);
        cimg = '0;
        rs = seed;
        for (int o = 0; o < NO; o++) begin
            rs = xs(rs);
            set_md(o, rs[0], rs[1]);
            for (int t = 0; t <= NP; t++)
                for (int i = 0; i < NA; i++)
                    for (int c = 0; c < 2; c++) begin
                        rs = xs(rs);
                        if ((t < NP) ? (rs[3:0] == 4'd0) : (rs[4:0] == 5'd0)) set_lnk(o, t, i, c);
                    end
        end
    endtask

    initial begin
        tg[0] = "R2"; tg[1] = "R4"; tg[2] = "R5"; tg[3] = "R5";
        tg[4] = "R6"; tg[5] = "R3"; tg[6] = "R3/R4"; tg[7] = "R7/R8";
        mq = '0;
        mh = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R12: reset state
        chk(cfg_ok === 1'b0, "R12", "cfg_ok after reset", {31'd0, cfg_ok}, 0);
        chk(pin_oe === '0, "R12", "pin_oe after reset", {24'd0, pin_oe}, 0);
        chk(pin_q === '0, "R12", "pin_q after reset", {24'd0, pin_q}, 0);
        chk(rb_bit === 1'b0, "R12", "rb_bit after reset", {31'd0, rb_bit}, 0);

        // R1: a short load never completes
        build_directed();
        load_img(5);
        step('0, "R1");

        // R1/R12: full load, first registered values, then function sweeps
        load_img(IW);
        step('0, "R12");
        sweep("");

        // R9: readback of the live image, array undisturbed afterwards
        rb_sweep(1'b0, "R9");
        for (int k = 0; k < 64; k++) step(NI'(k * 97), "R9");

        // R10: lock blanks readback, survives a reload
        @(negedge clk); lock_req = 1'b1; #1; model_eval(); model_adv();
        @(negedge clk); lock_req = 1'b0; #1; model_eval(); model_adv();
        rb_sweep(1'b1, "R10");
        for (int k = 0; k < 64; k++) step(NI'(k * 53 + 7), "R10");
        load_img(IW);
        rb_sweep(1'b1, "R10");

        // R11: erase wipes links, lock and cfg_ok
        @(negedge clk); erase_req = 1'b1; #1; model_eval(); model_adv();
        mvalid = 1'b0;
        @(negedge clk); erase_req = 1'b0; #1;
        chk(cfg_ok === 1'b0 && pin_oe === '0, "R11", "erase leaves device unconfigured",
            {23'd0, cfg_ok, pin_oe}, 0);
        model_eval(); model_adv();
        rb_sweep(1'b1, "R11");
        load_img(IW);
        rb_sweep(1'b0, "R11");
        for (int k = 0; k < 64; k++) step(NI'(k * 29 + 3), "R11");

        // R2: pseudo-random images
        build_random(32'h1234_5679);
        load_img(IW);
        sweep("R2");
        build_random(32'hBEEF_0421);
        load_img(IW);
        sweep("R2");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule